// File: doc/BRIEF.md
# Eight-bit Timer with Compare Output

This block is an 8-bit event timer. Its count advances by one on each clock cycle in which the timer enable `tick` is high. It has two counting modes. In free-running mode the count wraps from 0xFF to 0x00. In clear-on-compare mode the count returns to zero when it reaches a programmed compare value, so that value sets the period. Each pass through the compare value is recorded in a sticky match flag. Each wrap through zero is recorded in a sticky overflow flag. A match can also drive a single waveform pin.

Software uses a write-only register port, selected by `wr_addr`:

| Address | Meaning |
|---|---|
| 0 | Loads the counter. |
| 1 | Loads the compare value. |
| 2 | The control word. Bits [1:0] are the counting mode. Bits [3:2] are the pin action. Bit 7 is a force strobe. |
| 3 | Write-one-to-clear for the flags. Bit 0 clears the overflow flag and bit 1 clears the match flag. |

Separate acknowledge inputs also clear each flag, so an interrupt controller can clear them directly.

The pin is a two-state machine with states `PIN_LO` and `PIN_HI`. It moves only on a "fire" event, which is either a compare match or a force strobe.
- Transition `RISE` (`PIN_LO` to `PIN_HI`) is taken when the action is set or toggle.
- Transition `FALL` (`PIN_HI` to `PIN_LO`) is taken when the action is clear or toggle.
- In every other case the state holds (`KEEP`).

Top module: `tmr8_cmp_unit`

## Requirements
- R1: After reset, the following are all zero: count, compare value, both flags and the pin. The mode is free-running and the action is "no action".
- R2: Each cycle with `tick` high and no counter write increments the count by one. 0xFF wraps to 0x00. Without `tick` the count holds.
- R3: The overflow flag sets on the edge where a tick moves the count from 0xFF to 0x00. It stays set until one of these clears it: a write to address 3 with bit 0 = 1, or `ack_ovf`. A set in the same cycle wins over a clear.
- R4: Control bits [1:0] = 2'b10 selects clear-on-compare. In that mode, a tick while count equals the compare value loads 0 instead of count+1. Any other code (00, 01, 11) counts free-running. With compare value 0xFF, the return to zero also sets the overflow flag.
- R5: The match flag sets on the edge of a tick taken while count equals the compare value. This applies in both modes, and in free-running mode the count still increments. The flag is cleared by a write to address 3 with bit 1 = 1, or by `ack_cmp`.
- R6: On each compare match, the pin action in control bits [3:2] is applied. The encodings are 00 no action, 01 toggle, 10 drive low, 11 drive high.
- R7: Writing a new action does not change the pin. The new action first acts at the next compare match.
- R8: A control write with bit 7 = 1 applies the action in that same write to the pin at once. It does not set the match flag and does not clear the counter.
- R9: A write to address 0 loads the count at any time and takes priority over a tick in the same cycle. The next tick after the load gives no compare match: no flag, no pin action and no clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Timer clock enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 8 | Write data |
| ack_ovf | input | 1 | Clears the overflow flag |
| ack_cmp | input | 1 | Clears the match flag |
| count_o | output | 8 | Current count |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| cmp_flag_o | output | 1 | Sticky match flag |
| wave_o | output | 1 | Waveform pin |

## Verification
The hardest case to reach is a load that lands exactly on the compare value, because the match must then be suppressed for one tick. The bench loads the compare value into the counter while in clear-on-compare mode and applies a single tick. It then checks three things: the count moved past the compare value instead of returning to zero, the match flag stayed clear, and the pin stayed put. A second hard case is a load issued in the same cycle as a tick. The bench drives both together and checks that the loaded value wins.

// File: rtl/tc_pkg.sv
package tc_pkg;
    localparam int CNT_W  = 8;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_COUNT = 2'd0;
    localparam logic [ADDR_W-1:0] A_CMP   = 2'd1;
    localparam logic [ADDR_W-1:0] A_CTRL  = 2'd2;
    localparam logic [ADDR_W-1:0] A_CLR   = 2'd3;

    localparam int CTRL_MODE_LO = 0;
    localparam int CTRL_ACT_LO  = 2;
    localparam int CTRL_FORCE   = 7;
    localparam logic [1:0] MODE_CLR_ON_CMP = 2'b10;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'b00,
        ACT_TOGGLE = 2'b01,
        ACT_CLEAR  = 2'b10,
        ACT_SET    = 2'b11
    } act_e;

    typedef enum logic {
        PIN_LO = 1'b0,
        PIN_HI = 1'b1
    } pin_st_e;
endpackage

// File: rtl/tc_regs.sv
module tc_regs
    import tc_pkg::*;
#(
    parameter int W  = CNT_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic          ack_ovf,
    input  logic          ack_cmp,
    output logic          ld_en,
    output logic [W-1:0]  ld_val,
    output logic [W-1:0]  cmp_val,
    output logic          ctc_en,
    output act_e          act_q,
    output logic          force_ev,
    output act_e          force_act,
    output logic          clr_ovf,
    output logic          clr_cmp
);
    logic       wr_ctrl;
    logic [1:0] mode_q;
    logic       unused_bits;

    assign wr_ctrl   = wr_en && (wr_addr == A_CTRL);
    assign ld_en     = wr_en && (wr_addr == A_COUNT);
    assign ld_val    = wr_data;
    assign force_ev  = wr_ctrl && wr_data[CTRL_FORCE];
    assign force_act = act_e'(wr_data[CTRL_ACT_LO +: 2]);
    assign clr_ovf   = (wr_en && (wr_addr == A_CLR) && wr_data[0]) || ack_ovf;
    assign clr_cmp   = (wr_en && (wr_addr == A_CLR) && wr_data[1]) || ack_cmp;
    assign ctc_en    = (mode_q == MODE_CLR_ON_CMP);
    assign unused_bits = ^wr_data[CTRL_FORCE-1:CTRL_ACT_LO+2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_val <= '0;
            mode_q  <= 2'b00;
            act_q   <= ACT_NONE;
        end else if (wr_en) begin
            if (wr_addr == A_CMP) cmp_val <= wr_data;
            if (wr_ctrl) begin
                mode_q <= wr_data[CTRL_MODE_LO +: 2];
                act_q  <= act_e'(wr_data[CTRL_ACT_LO +: 2]);
            end
        end
    end

    // R8: a force strobe only exists on a control write
    a_r8_force_on_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
        force_ev |-> (wr_en && wr_addr == A_CTRL));
endmodule

// File: rtl/tc_count.sv
module tc_count
    import tc_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         ld_en,
    input  logic [W-1:0] ld_val,
    input  logic [W-1:0] cmp_val,
    input  logic         ctc_en,
    input  logic         clr_ovf,
    input  logic         clr_cmp,
    output logic [W-1:0] cnt_q,
    output logic         ovf_q,
    output logic         cmpf_q,
    output logic         match_ev
);
    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    logic blk_q;
    logic adv;
    logic ovf_set;

    assign adv      = tick && !ld_en;
    assign match_ev = adv && !blk_q && (cnt_q == cmp_val);
    assign ovf_set  = adv && (cnt_q == CNT_MAX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            blk_q <= 1'b0;
        end else if (ld_en) begin
            cnt_q <= ld_val;
            blk_q <= 1'b1;
        end else if (tick) begin
            cnt_q <= (ctc_en && match_ev) ? '0 : cnt_q + 1'b1;
            blk_q <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovf_q  <= 1'b0;
            cmpf_q <= 1'b0;
        end else begin
            if (ovf_set)      ovf_q <= 1'b1;
            else if (clr_ovf) ovf_q <= 1'b0;
            if (match_ev)     cmpf_q <= 1'b1;
            else if (clr_cmp) cmpf_q <= 1'b0;
        end
    end

    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !ld_en) |=> $stable(cnt_q));
    a_r3_wrap_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && cnt_q == CNT_MAX) |=> (cnt_q == '0 && ovf_q));
    a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !clr_ovf) |=> ovf_q);
    a_r4_ctc_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (ctc_en && match_ev) |=> (cnt_q == '0));
    a_r5_cmp_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (cmpf_q && !clr_cmp) |=> cmpf_q);
    a_r9_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |=> (cnt_q == $past(ld_val)));
    a_r9_block_next: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |=> !match_ev);
endmodule

// File: rtl/tc_wave.sv
module tc_wave
    import tc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic match_ev,
    input  act_e act_q,
    input  logic force_ev,
    input  act_e force_act,
    output logic wave_o
);
    pin_st_e st_q, st_d;
    act_e    act_use;
    logic    fire;

    assign fire    = force_ev || match_ev;
    assign act_use = force_ev ? force_act : act_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            PIN_LO: if (fire && (act_use == ACT_SET || act_use == ACT_TOGGLE))
                        st_d = PIN_HI;
            PIN_HI: if (fire && (act_use == ACT_CLEAR || act_use == ACT_TOGGLE))
                        st_d = PIN_LO;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= PIN_LO;
        else        st_q <= st_d;
    end

    always_comb wave_o = (st_q == PIN_HI);

    a_r7_no_fire_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> $stable(wave_o));
    a_r6_set_high: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && act_use == ACT_SET) |=> wave_o);
    a_r6_clear_low: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && act_use == ACT_CLEAR) |=> !wave_o);
    a_r6_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && act_use == ACT_TOGGLE) |=> (wave_o != $past(wave_o)));
endmodule

// File: rtl/tmr8_cmp_unit.sv
module tmr8_cmp_unit
    import tc_pkg::*;
#(
    parameter int W  = CNT_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic          ack_ovf,
    input  logic          ack_cmp,
    output logic [W-1:0]  count_o,
    output logic          ovf_flag_o,
    output logic          cmp_flag_o,
    output logic          wave_o
);
    logic         ld_en, ctc_en, force_ev, clr_ovf, clr_cmp, match_ev;
    logic [W-1:0] ld_val, cmp_val;
    act_e         act_q, force_act;

    tc_regs #(.W(W), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .ack_ovf(ack_ovf), .ack_cmp(ack_cmp),
        .ld_en(ld_en), .ld_val(ld_val), .cmp_val(cmp_val), .ctc_en(ctc_en),
        .act_q(act_q), .force_ev(force_ev), .force_act(force_act),
        .clr_ovf(clr_ovf), .clr_cmp(clr_cmp)
    );

    tc_count #(.W(W)) u_count (
        .clk(clk), .rst_n(rst_n), .tick(tick), .ld_en(ld_en), .ld_val(ld_val),
        .cmp_val(cmp_val), .ctc_en(ctc_en), .clr_ovf(clr_ovf),
        .clr_cmp(clr_cmp), .cnt_q(count_o), .ovf_q(ovf_flag_o),
        .cmpf_q(cmp_flag_o), .match_ev(match_ev)
    );

    tc_wave u_wave (
        .clk(clk), .rst_n(rst_n), .match_ev(match_ev), .act_q(act_q),
        .force_ev(force_ev), .force_act(force_act), .wave_o(wave_o)
    );

    // R8: a lone force strobe leaves the match flag as it was
    a_r8_force_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (force_ev && !tick && !cmp_flag_o) |=> !cmp_flag_o);
endmodule

// File: tb/test_tmr8_cmp_unit.sv
module test_tmr8_cmp_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       ack_ovf = 1'b0;
    logic       ack_cmp = 1'b0;
    logic [7:0] count_o;
    logic       ovf_flag_o, cmp_flag_o, wave_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tmr8_cmp_unit i_tmr8_cmp_unit (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .ack_ovf(ack_ovf),
        .ack_cmp(ack_cmp), .count_o(count_o), .ovf_flag_o(ovf_flag_o),
        .cmp_flag_o(cmp_flag_o), .wave_o(wave_o)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr_with_tick(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d; tick = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tick = 1'b0;
    endtask

    task automatic tick_n(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick = 1'b1;
        end
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 count", count_o, 8'h00);
        chk("R1 ovf", {7'b0, ovf_flag_o}, 8'h00);
        chk("R1 cmp flag", {7'b0, cmp_flag_o}, 8'h00);
        chk("R1 pin", {7'b0, wave_o}, 8'h00);
    endtask

    task automatic t_free_wrap();
        wr(2'd1, 8'h80);
        wr(2'd2, 8'h00);
        wr(2'd0, 8'hFD);
        tick_n(2);
        chk("R2 count up", count_o, 8'hFF);
        chk("R3 no ovf before wrap", {7'b0, ovf_flag_o}, 8'h00);
        tick_n(1);
        chk("R2 wrap", count_o, 8'h00);
        chk("R3 ovf on wrap", {7'b0, ovf_flag_o}, 8'h01);
        repeat (3) @(negedge clk);
        chk("R2 hold without tick", count_o, 8'h00);
        chk("R3 ovf sticky", {7'b0, ovf_flag_o}, 8'h01);
        wr(2'd3, 8'h01);
        chk("R3 w1c", {7'b0, ovf_flag_o}, 8'h00);
        wr(2'd0, 8'hFF);
        tick_n(1);
        chk("R3 ovf again", {7'b0, ovf_flag_o}, 8'h01);
        @(negedge clk); ack_ovf = 1'b1;
        @(negedge clk); ack_ovf = 1'b0;
        chk("R3 ack clears", {7'b0, ovf_flag_o}, 8'h00);
        chk("R5 no match seen", {7'b0, cmp_flag_o}, 8'h00);
    endtask

    task automatic t_ctc_toggle();
        wr(2'd1, 8'h05);
        wr(2'd2, 8'h06);
        wr(2'd0, 8'h00);
        tick_n(5);
        chk("R4 at compare", count_o, 8'h05);
        chk("R5 flag before match", {7'b0, cmp_flag_o}, 8'h00);
        chk("R7 pin before match", {7'b0, wave_o}, 8'h00);
        tick_n(1);
        chk("R4 ctc clear", count_o, 8'h00);
        chk("R5 flag set", {7'b0, cmp_flag_o}, 8'h01);
        chk("R6 toggle high", {7'b0, wave_o}, 8'h01);
        wr(2'd3, 8'h02);
        chk("R5 w1c", {7'b0, cmp_flag_o}, 8'h00);
        tick_n(6);
        chk("R6 toggle low", {7'b0, wave_o}, 8'h00);
        chk("R4 period", count_o, 8'h00);
        @(negedge clk); ack_cmp = 1'b1;
        @(negedge clk); ack_cmp = 1'b0;
        chk("R5 ack clears", {7'b0, cmp_flag_o}, 8'h00);
    endtask

    task automatic t_actions();
        wr(2'd2, 8'h0E);
        chk("R7 set written no change", {7'b0, wave_o}, 8'h00);
        tick_n(6);
        chk("R6 set", {7'b0, wave_o}, 8'h01);
        wr(2'd2, 8'h02);
        tick_n(6);
        chk("R6 none holds", {7'b0, wave_o}, 8'h01);
        wr(2'd2, 8'h0A);
        chk("R7 clear written no change", {7'b0, wave_o}, 8'h01);
        tick_n(6);
        chk("R6 clear", {7'b0, wave_o}, 8'h00);
    endtask

    task automatic t_force();
        wr(2'd3, 8'h02);
        wr(2'd0, 8'h03);
        wr(2'd2, 8'h8E);
        chk("R8 force set", {7'b0, wave_o}, 8'h01);
        chk("R8 no flag", {7'b0, cmp_flag_o}, 8'h00);
        chk("R8 no clear", count_o, 8'h03);
        wr(2'd2, 8'h86);
        chk("R8 force toggle", {7'b0, wave_o}, 8'h00);
        tick_n(3);
        chk("R6 toggle after force", {7'b0, wave_o}, 8'h01);
        chk("R4 clear after force", count_o, 8'h00);
    endtask

    task automatic t_block();
        wr(2'd2, 8'h02);
        wr(2'd3, 8'h03);
        wr(2'd0, 8'h05);
        tick_n(1);
        chk("R9 blocked no clear", count_o, 8'h06);
        chk("R9 blocked no flag", {7'b0, cmp_flag_o}, 8'h00);
        chk("R9 blocked no pin", {7'b0, wave_o}, 8'h01);
        wr_with_tick(2'd0, 8'h40);
        chk("R9 load beats tick", count_o, 8'h40);
        tick_n(1);
        chk("R9 count after load", count_o, 8'h41);
    endtask

    task automatic t_ctc_top();
        wr(2'd1, 8'hFF);
        wr(2'd0, 8'hFE);
        wr(2'd3, 8'h03);
        tick_n(2);
        chk("R4 ctc top returns to zero", count_o, 8'h00);
        chk("R4 ctc top sets ovf", {7'b0, ovf_flag_o}, 8'h01);
        chk("R5 flag at top", {7'b0, cmp_flag_o}, 8'h01);
    endtask

    task automatic t_free_match();
        wr(2'd2, 8'h01);
        wr(2'd1, 8'h10);
        wr(2'd0, 8'h0F);
        wr(2'd3, 8'h03);
        tick_n(2);
        chk("R4 code 01 free-running", count_o, 8'h11);
        chk("R5 free match flag", {7'b0, cmp_flag_o}, 8'h01);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_free_wrap();
        t_ctc_toggle();
        t_actions();
        t_force();
        t_block();
        t_ctc_top();
        t_free_match();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++;
                n_fail++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule